// File: doc/BRIEF.md
# I2C SCL timing generator

This block produces the serial clock for an I2C master. Software keeps one high-count and one low-count value for each speed class (standard, fast, high-speed). A two-bit speed field selects which pair is used. The high phase of SCL is stretched by a fixed overhead of seven clocks and by a programmable spike-suppression length. The low phase gets a one-clock overhead. A programmable hold count sets how long after each SCL falling edge the data line must stay still. After that, an SDA-change permission is raised for the rest of the low phase.

A bit-level sequencer uses the block as follows:
1. Program the counts while the block is disabled.
2. Raise the enable.
3. Use the one-cycle rise and fall strobes and the SDA permission to place data bits.

The block samples the SCL line back. When a target holds the line low while the master has released it, the high-phase counter pauses.

Top module: `scl_timing_gen`

## Requirements
- R1: The speed field selects the count pair: 01 selects standard (pair 0), 10 selects fast (pair 1), 11 selects high-speed (pair 2), and 00 behaves as standard.
- R2: The write port uses these addresses: 0 and 1 are the standard high and low counts, 2 and 3 the fast pair, 4 and 5 the high-speed pair, 6 the standard/fast spike length, 7 the high-speed spike length, and 8 the SDA hold count. Each pair affects only its own class.
- R3: The SCL high phase lasts high count + spike length + 7 clock cycles when the line is not held low.
- R4: The SCL low phase lasts low count + 1 clock cycles.
- R5: Standard and fast classes use the spike length at address 6. The high-speed class uses the one at address 7.
- R6: `fall_o` is a one-cycle pulse in the first cycle that `scl_o` is low. `rise_o` is a one-cycle pulse in the first cycle that `scl_o` is high. The first cycle after enable begins a low phase with a fall pulse.
- R7: While `scl_o` is high and `scl_i` reads low, the high-phase count is held, so each such cycle lengthens the high phase by one cycle, including on its last cycle.
- R8: One cycle after `en_i` is low, `scl_o` is 1 (released) and `rise_o`, `fall_o` and `sda_ok_o` are 0. A later enable restarts with a fresh low phase.
- R9: `sda_ok_o` is 0 for the first hold-count cycles of each low phase and 1 for the rest of it. It is never 1 in a low phase no longer than the hold count, and it is 0 while SCL is high.
- R10: A register write while `en_i` is high, or in the cycle the block is still winding down, is ignored.
- R11: After reset, the counts equal ceil(CLK_MHZ × t / 1000) for t = 4000/4700, 600/1300 and 60/160 ns (high/low for the three classes), and 300 ns for the hold count. Both spike lengths reset to 1.
- R12: The speed field is captured when generation starts. Changing it while enabled has no effect until the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the SCL generator |
| speed_i | input | 2 | Speed class select |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| scl_i | input | 1 | Sampled SCL line level |
| scl_o | output | 1 | SCL drive, 0 pulls low, 1 releases |
| rise_o | output | 1 | Pulse in the first high cycle |
| fall_o | output | 1 | Pulse in the first low cycle |
| sda_ok_o | output | 1 | SDA may change in this cycle |

## Verification
A target stretch can arrive in the same cycle as the high-phase terminal count. The bench provokes this by pulling `scl_i` low on the last high cycle and on the first one. It judges the result from the measured high length, which must equal the nominal length plus the stretched cycles in both cases. A register write can also meet a running phase. The bench writes the active pair mid-period and then checks that the next periods, and a period after a re-enable, keep the old lengths.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  localparam int NUM_CLS = 3;

  typedef enum logic [1:0] {
    SPD_NONE = 2'b00,
    SPD_STD  = 2'b01,
    SPD_FAST = 2'b10,
    SPD_HIGH = 2'b11
  } spd_e;

  localparam logic [3:0] ADDR_SPK_FS = 4'd6;
  localparam logic [3:0] ADDR_SPK_HS = 4'd7;
  localparam logic [3:0] ADDR_HOLD   = 4'd8;

  function automatic int ns2cyc(input int mhz, input int ns);
    return (mhz * ns + 999) / 1000;
  endfunction

  function automatic int def_hi_ns(input int cls);
    case (cls)
      0: return 4000;
      1: return 600;
      default: return 60;
    endcase
  endfunction

  function automatic int def_lo_ns(input int cls);
    case (cls)
      0: return 4700;
      1: return 1300;
      default: return 160;
    endcase
  endfunction
endpackage

// File: rtl/scl_tg_regs.sv
module scl_tg_regs
  import scl_tg_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SPK_W   = 8,
  parameter int CLK_MHZ = 100
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          lock_i,
  input  logic                          wr_en_i,
  input  logic [3:0]                    wr_addr_i,
  input  logic [CNT_W-1:0]              wr_data_i,
  output logic [NUM_CLS-1:0][CNT_W-1:0] hcnt_o,
  output logic [NUM_CLS-1:0][CNT_W-1:0] lcnt_o,
  output logic [SPK_W-1:0]              spk_fs_o,
  output logic [SPK_W-1:0]              spk_hs_o,
  output logic [CNT_W-1:0]              hold_o
);
  localparam logic [CNT_W-1:0] DEF_HOLD = CNT_W'(ns2cyc(CLK_MHZ, 300));

  logic wr_ok;
  assign wr_ok = wr_en_i && !lock_i;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    localparam logic [CNT_W-1:0] DEF_H = CNT_W'(ns2cyc(CLK_MHZ, def_hi_ns(c)));
    localparam logic [CNT_W-1:0] DEF_L = CNT_W'(ns2cyc(CLK_MHZ, def_lo_ns(c)));
    localparam logic [3:0] A_H = 4'(2 * c);
    localparam logic [3:0] A_L = 4'(2 * c + 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hcnt_o[c] <= DEF_H;
        lcnt_o[c] <= DEF_L;
      end else if (wr_ok) begin
        if (wr_addr_i == A_H) hcnt_o[c] <= wr_data_i;
        if (wr_addr_i == A_L) lcnt_o[c] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spk_fs_o <= SPK_W'(1);
      spk_hs_o <= SPK_W'(1);
      hold_o   <= DEF_HOLD;
    end else if (wr_ok) begin
      if (wr_addr_i == ADDR_SPK_FS) spk_fs_o <= wr_data_i[SPK_W-1:0];
      if (wr_addr_i == ADDR_SPK_HS) spk_hs_o <= wr_data_i[SPK_W-1:0];
      if (wr_addr_i == ADDR_HOLD)   hold_o   <= wr_data_i;
    end
  end
endmodule

// File: rtl/scl_tg_sel.sv
module scl_tg_sel
  import scl_tg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SPK_W = 8,
  parameter int LEN_W = CNT_W + 2
) (
  input  spd_e                          spd_i,
  input  logic [NUM_CLS-1:0][CNT_W-1:0] hcnt_i,
  input  logic [NUM_CLS-1:0][CNT_W-1:0] lcnt_i,
  input  logic [SPK_W-1:0]              spk_fs_i,
  input  logic [SPK_W-1:0]              spk_hs_i,
  output logic [LEN_W-1:0]              high_len_o,
  output logic [LEN_W-1:0]              low_len_o
);
  localparam logic [LEN_W-1:0] HI_OVH = LEN_W'(7);
  localparam logic [LEN_W-1:0] LO_OVH = LEN_W'(1);

  logic [1:0]       cls;
  logic [SPK_W-1:0] spk;

  always_comb begin
    case (spd_i)
      SPD_HIGH: cls = 2'd2;
      SPD_FAST: cls = 2'd1;
      default:  cls = 2'd0;
    endcase
    spk        = (spd_i == SPD_HIGH) ? spk_hs_i : spk_fs_i;
    high_len_o = LEN_W'(hcnt_i[cls]) + LEN_W'(spk) + HI_OVH;
    low_len_o  = LEN_W'(lcnt_i[cls]) + LO_OVH;
  end
endmodule

// File: rtl/scl_tg_phase.sv
module scl_tg_phase
  import scl_tg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       speed_i,
  input  logic             scl_i,
  input  logic [LEN_W-1:0] high_len_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [CNT_W-1:0] hold_i,
  output spd_e             spd_o,
  output logic             run_o,
  output logic             scl_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             sda_ok_o
);
  logic             hi_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      hi_q   <= 1'b1;
      cnt_q  <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      spd_o  <= SPD_STD;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (!en_i) begin
        run_o <= 1'b0;
        hi_q  <= 1'b1;
        cnt_q <= '0;
      end else if (!run_o) begin
        run_o  <= 1'b1;
        hi_q   <= 1'b0;
        cnt_q  <= '0;
        fall_o <= 1'b1;
        spd_o  <= (spd_e'(speed_i) == SPD_NONE) ? SPD_STD : spd_e'(speed_i);
      end else if (!hi_q) begin
        if (cnt_q == low_len_i - 1'b1) begin
          hi_q   <= 1'b1;
          cnt_q  <= '0;
          rise_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (scl_i) begin
        // count only once the line has actually risen (target stretch)
        if (cnt_q == high_len_i - 1'b1) begin
          hi_q   <= 1'b0;
          cnt_q  <= '0;
          fall_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign scl_o    = !run_o || hi_q;
  assign sda_ok_o = run_o && !hi_q && (cnt_q >= LEN_W'(hold_i));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SPK_W   = 8,
  parameter int CLK_MHZ = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       speed_i,
  input  logic             wr_en_i,
  input  logic [3:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             scl_i,
  output logic             scl_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             sda_ok_o
);
  localparam int LEN_W = CNT_W + 2;

  logic [NUM_CLS-1:0][CNT_W-1:0] hcnt, lcnt;
  logic [SPK_W-1:0]              spk_fs, spk_hs;
  logic [CNT_W-1:0]              hold;
  logic [LEN_W-1:0]              high_len, low_len;
  spd_e                          spd_q;
  logic                          run_q;

  scl_tg_regs #(.CNT_W(CNT_W), .SPK_W(SPK_W), .CLK_MHZ(CLK_MHZ)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (en_i || run_q),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .hcnt_o    (hcnt),
    .lcnt_o    (lcnt),
    .spk_fs_o  (spk_fs),
    .spk_hs_o  (spk_hs),
    .hold_o    (hold)
  );

  scl_tg_sel #(.CNT_W(CNT_W), .SPK_W(SPK_W), .LEN_W(LEN_W)) u_sel (
    .spd_i      (spd_q),
    .hcnt_i     (hcnt),
    .lcnt_i     (lcnt),
    .spk_fs_i   (spk_fs),
    .spk_hs_i   (spk_hs),
    .high_len_o (high_len),
    .low_len_o  (low_len)
  );

  scl_tg_phase #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .speed_i    (speed_i),
    .scl_i      (scl_i),
    .high_len_i (high_len),
    .low_len_i  (low_len),
    .hold_i     (hold),
    .spd_o      (spd_q),
    .run_o      (run_q),
    .scl_o      (scl_o),
    .rise_o     (rise_o),
    .fall_o     (fall_o),
    .sda_ok_o   (sda_ok_o)
  );
endmodule

// File: rtl/scl_tg_chk.sv
module scl_tg_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic run_i,
  input logic scl_i,
  input logic scl_o,
  input logic rise_o,
  input logic fall_o,
  input logic sda_ok_o
);
  a_r6_fall_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> !scl_o);
  a_r6_rise_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> scl_o);
  a_r6_one_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
  a_r6_fall_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !rise_o && !fall_o && !sda_ok_o));
  a_r9_sda_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_ok_o |-> !scl_o);
  a_r9_sda_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_ok_o && en_i && !rise_o) |=> (sda_ok_o || rise_o));
  a_r7_stretch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && en_i && scl_o && !scl_i) |=> (scl_o && !fall_o));
endmodule

bind scl_timing_gen scl_tg_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .run_i    (run_q),
  .scl_i    (scl_i),
  .scl_o    (scl_o),
  .rise_o   (rise_o),
  .fall_o   (fall_o),
  .sda_ok_o (sda_ok_o)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [1:0]       speed = 2'b01;
  logic             wr_en = 1'b0;
  logic [3:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             hold_low = 1'b0;
  logic             scl_o, rise_o, fall_o, sda_ok_o;
  logic             scl_i;

  int n_run = 0;
  int n_fail = 0;

  assign scl_i = scl_o && !hold_low;

  always #5 clk = ~clk;

  scl_timing_gen #(.CNT_W(CNT_W)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .speed_i   (speed),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .scl_i     (scl_i),
    .scl_o     (scl_o),
    .rise_o    (rise_o),
    .fall_o    (fall_o),
    .sda_ok_o  (sda_ok_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1;
    wr_addr = 4'(a);
    wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic disable_gen();
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic enable_gen();
    en = 1'b1;
    @(negedge clk);
  endtask

  // measures one low phase and the following high phase
  task automatic measure(input int exp_l, input int exp_h, input int exp_sda,
                         input int st_at, input int st_len, input string req);
    int guard, low, high, sda_first, left;
    bit lvl_ok;
    guard = 0;
    while (!fall_o && guard < 5000) begin guard++; @(negedge clk); end
    low = 0; sda_first = -1; lvl_ok = 1;
    while (!rise_o && guard < 5000) begin
      if (scl_o !== 1'b0) lvl_ok = 0;
      if (sda_ok_o && sda_first < 0) sda_first = low;
      low++; guard++;
      @(negedge clk);
    end
    high = 0; left = 0;
    while (!fall_o && guard < 5000) begin
      if (scl_o !== 1'b1 || sda_ok_o) lvl_ok = 0;
      if (high == st_at && st_len > 0) left = st_len;
      hold_low = (left > 0);
      if (left > 0) left--;
      high++; guard++;
      @(negedge clk);
    end
    hold_low = 1'b0;
    chk(low == exp_l, "R4", {req, " low length"}, low, exp_l);
    chk(high == exp_h, "R3", {req, " high length"}, high, exp_h);
    chk(sda_first == exp_sda, "R9", {req, " sda permission index"}, sda_first, exp_sda);
    chk(lvl_ok, "R6", {req, " levels during phases"}, int'(lvl_ok), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int h_len, l_len, ec, hd, exp_sda;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 / R8: reset idle state
    chk(scl_o === 1'b1 && !rise_o && !fall_o && !sda_ok_o, "R8", "reset idle outputs",
        int'({scl_o, rise_o, fall_o, sda_ok_o}), 8);

    // R11: defaults at 100 MHz
    speed = 2'b01;
    enable_gen();
    measure(471, 408, 30, -1, 0, "R11 std default");
    disable_gen();
    speed = 2'b11;
    enable_gen();
    measure(17, 14, -1, -1, 0, "R11 hs default");
    disable_gen();
    chk(scl_o === 1'b1 && !fall_o && !rise_o, "R8", "released after disable", int'(scl_o), 1);

    // R1 R2 R3 R4 R5 R9: sweep over speed field and counts
    wr(6, 2);
    wr(7, 5);
    for (int s = 0; s < 4; s++) begin
      for (int h = 0; h < 4; h += 2) begin
        for (int l = 0; l < 6; l += 2) begin
          for (int c = 0; c < 3; c++) begin
            wr(2 * c, h + 4 * c);
            wr(2 * c + 1, l + 3 * c);
          end
          hd = (h + l + s) % 7;
          wr(8, hd);
          ec = (s == 0) ? 0 : s - 1;
          h_len = h + 4 * ec + ((ec == 2) ? 5 : 2) + 7;
          l_len = l + 3 * ec + 1;
          exp_sda = (hd < l_len) ? hd : -1;
          speed = 2'(s);
          enable_gen();
          chk(fall_o === 1'b1 && scl_o === 1'b0, "R6", "fall pulse one cycle after enable",
              int'(fall_o), 1);
          measure(l_len, h_len, exp_sda, -1, 0, "R1 R2 R5 sweep");
          measure(l_len, h_len, exp_sda, -1, 0, "R1 R2 R5 sweep repeat");
          disable_gen();
        end
      end
    end

    // R10: writes while enabled are ignored
    wr(0, 2); wr(1, 3); wr(6, 2); wr(8, 1);
    speed = 2'b01;
    enable_gen();
    measure(4, 11, 1, -1, 0, "R10 base");
    wr(0, 9);
    wr(1, 9);
    measure(4, 11, 1, -1, 0, "R10 write while enabled");
    en = 1'b0;
    wr(0, 9);
    @(negedge clk);
    enable_gen();
    measure(4, 11, 1, -1, 0, "R10 write while winding down");
    disable_gen();
    wr(0, 9);
    enable_gen();
    measure(4, 18, 1, -1, 0, "R10 write while disabled");
    disable_gen();
    wr(0, 2);

    // R7: stretch at start, middle and terminal cycle of the high phase
    enable_gen();
    measure(4, 15, 1, 0, 4, "R7 stretch first cycle");
    measure(4, 14, 1, 10, 3, "R7 stretch terminal cycle");
    measure(4, 12, 1, 5, 1, "R7 stretch middle");
    disable_gen();

    // R12: speed captured at start
    wr(4, 0); wr(5, 0); wr(7, 1);
    speed = 2'b01;
    enable_gen();
    measure(4, 11, 1, -1, 0, "R12 before change");
    speed = 2'b11;
    measure(4, 11, 1, -1, 0, "R12 after change");
    disable_gen();
    enable_gen();
    measure(1, 8, -1, -1, 0, "R12 after re-enable");
    disable_gen();

    // R8: disable in the middle of a low phase, then restart
    speed = 2'b01;
    wr(1, 20);
    enable_gen();
    repeat (3) @(negedge clk);
    chk(scl_o === 1'b0, "R8", "low before disable", int'(scl_o), 0);
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(scl_o === 1'b1 && !rise_o && !fall_o && !sda_ok_o, "R8", "idle after mid-phase disable",
          int'({scl_o, rise_o, fall_o, sda_ok_o}), 8);
    end
    en = 1'b1;
    @(negedge clk);
    chk(fall_o === 1'b1 && scl_o === 1'b0, "R8", "restart with fall", int'(fall_o), 1);
    measure(21, 11, 1, -1, 0, "R8 restart");
    disable_gen();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule